// File: doc/BRIEF.md
# Greedy Max-Min CTA Partition Engine

This block chooses how many thread blocks each of several co-running kernels gets on one shader core. Two tables, loaded beforehand, hold for each kernel and each block count T (1..N) a normalized throughput and a resource cost. After a start pulse, every kernel is given one block. The engine then repeatedly picks the kernel with the lowest current throughput and gives it one more block. It does this as long as the summed cost stays within the core's budget and no kernel goes past N blocks.

The result is a vector of per-kernel block counts and a one-bit verdict. The verdict says whether the core should be shared this way or whether the kernels should instead be spread across cores (spatial multitasking). The tables are loaded through a valid/ready write stream. The source may present a beat at any time. A beat transfers on a cycle where both valid and ready are high. Ready is low for the whole of a computation, and the source must then hold its beat unchanged until ready returns. The budget, the threshold and the start pulse are plain control inputs.

Top module: `wf_partition_engine`

## Requirements
- R1: A table beat transfers when `wr_valid` and `wr_ready` are both high. `wr_sel`=0 selects the throughput table and `wr_sel`=1 the cost table. `wr_cnt` (1..N) is the block count the entry describes. `wr_ready` is low while `busy` is high, so a beat offered during a computation does not change its result.
- R2: A `start` pulse while idle raises `busy` on the next cycle. A `start` while busy is ignored and produces no second `done`.
- R3: Every kernel starts with one block. If the summed one-block costs exceed `r_total`, the engine finishes with all counts equal to 1 and `spatial` set.
- R4: Each step adds exactly one block to the kernel whose throughput at its current count is the lowest (unsigned compare). On a tie, the lowest kernel index is chosen.
- R5: The engine stops at the first step where the chosen kernel cannot grow. It does not then try any other kernel.
- R6: When R3 does not apply, the summed costs at the final counts are at most `r_total`. An exactly equal sum is allowed.
- R7: No count ever exceeds N.
- R8: When R3 does not apply, `spatial` is set exactly when the summed final throughput is below `thresh`. A sum equal to `thresh` clears it.
- R9: `done` is a one-cycle pulse. It arrives at most K*(N-1)+3 cycles after `start`. Counts and `spatial` hold until the next accepted `start`.
- R10: After reset, all counts are 0, `done`, `busy` and `spatial` are low, and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Table write beat present |
| wr_ready | output | 1 | Engine can take a table beat |
| wr_sel | input | 1 | 0 = throughput table, 1 = cost table |
| wr_kern | input | KW | Kernel index of the entry |
| wr_cnt | input | CW | Block count (1..N) the entry describes |
| wr_data | input | DW | Entry value, unsigned |
| r_total | input | DW | Core resource budget |
| thresh | input | DW+KW | Minimum summed throughput for sharing |
| start | input | 1 | Begin a computation |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| spatial | output | 1 | Spread kernels across cores instead |
| cta_counts | output | K*CW | Per-kernel block counts, kernel k at bits [k*CW +: CW] |

## Verification
The hardest situations to reach are the two ways the greedy loop ends. In one, the lowest kernel is refused while another kernel would still fit. In the other, several kernels tie and the index order decides. Both need throughput curves and costs chosen together. The bench builds throughput tables that are equal for every kernel, so the tie order shows in the counts. It sets the budget so that it runs out exactly as the lagging kernel comes up. Separate runs put the budget one unit below and exactly at the one-block sum, and the threshold one unit above and exactly at the final throughput sum.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_STEP = 2'd2
  } wf_state_e;
endpackage

// File: rtl/wf_table.sv
module wf_table #(
  parameter int K  = 3,
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int KW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [KW-1:0] wk,
  input  logic [CW-1:0] wc,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q [K][N]
);
  // entries addressed by block count 1..N; out-of-range beats are dropped
  for (genvar k = 0; k < K; k++) begin : g_kern
    for (genvar t = 0; t < N; t++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q[k][t] <= '0;
        end else if (we && (wk == KW'(k)) && (wc == CW'(t + 1))) begin
          q[k][t] <= wd;
        end
      end
    end
  end
endmodule

// File: rtl/wf_minsel.sv
module wf_minsel #(
  parameter int K  = 3,
  parameter int DW = 16,
  parameter int KW = 2
) (
  input  logic [DW-1:0] val [K],
  output logic [KW-1:0] idx
);
  logic [DW-1:0] best;
  // strict less-than keeps the lowest index on ties
  always_comb begin
    idx  = '0;
    best = val[0];
    for (int i = 1; i < K; i++) begin
      if (val[i] < best) begin
        best = val[i];
        idx  = KW'(i);
      end
    end
  end
endmodule

// File: rtl/wf_fit.sv
module wf_fit #(
  parameter int K   = 3,
  parameter int N   = 4,
  parameter int DW  = 16,
  parameter int KW  = 2,
  parameter int CW  = 3,
  parameter int SW  = 19,
  parameter int PSW = 18
) (
  input  logic [CW-1:0]  cnt [K],
  input  logic [DW-1:0]  perf_q [K][N],
  input  logic [DW-1:0]  cost_q [K][N],
  input  logic [KW-1:0]  sel,
  input  logic [DW-1:0]  r_total,
  output logic [DW-1:0]  cur_perf [K],
  output logic [SW-1:0]  sum_cost,
  output logic [PSW-1:0] perf_sum,
  output logic           grow_ok
);
  localparam int NIW = (N > 1) ? $clog2(N) : 1;

  logic [DW-1:0] cur_cost [K];
  logic [DW-1:0] nxt_cost [K];
  logic [SW-1:0] trial;

  for (genvar i = 0; i < K; i++) begin : g_rd
    logic [NIW-1:0] cidx;
    assign cidx        = (cnt[i] == '0) ? '0 : NIW'(cnt[i] - 1'b1);
    assign cur_perf[i] = perf_q[i][cidx];
    assign cur_cost[i] = cost_q[i][cidx];
    assign nxt_cost[i] = (cnt[i] < CW'(N)) ? cost_q[i][NIW'(cnt[i])] : '0;
  end

  always_comb begin
    sum_cost = '0;
    perf_sum = '0;
    for (int i = 0; i < K; i++) begin
      sum_cost = sum_cost + SW'(cur_cost[i]);
      perf_sum = perf_sum + PSW'(cur_perf[i]);
    end
  end

  // budget with the chosen kernel moved one step up its cost curve
  assign trial   = sum_cost - SW'(cur_cost[sel]) + SW'(nxt_cost[sel]);
  assign grow_ok = (cnt[sel] < CW'(N)) && (trial <= SW'(r_total));
endmodule

// File: rtl/wf_partition_engine.sv
module wf_partition_engine #(
  parameter int K  = 3,
  parameter int N  = 4,
  parameter int DW = 16,
  localparam int KW = (K > 1) ? $clog2(K) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_sel,
  input  logic [KW-1:0]    wr_kern,
  input  logic [CW-1:0]    wr_cnt,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    r_total,
  input  logic [DW+KW-1:0] thresh,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             spatial,
  output logic [K*CW-1:0]  cta_counts
);
  import wf_pkg::*;

  localparam int SW  = DW + KW + 1;
  localparam int PSW = DW + KW;

  wf_state_e      state_q;
  logic [CW-1:0]  cnt_q [K];
  logic [DW-1:0]  perf_q [K][N];
  logic [DW-1:0]  cost_q [K][N];
  logic [DW-1:0]  cur_perf [K];
  logic [KW-1:0]  sel;
  logic [SW-1:0]  sum_cost;
  logic [PSW-1:0] perf_sum;
  logic           grow_ok;
  logic           beat;

  assign busy     = (state_q != ST_IDLE);
  assign wr_ready = !busy;
  assign beat     = wr_valid && wr_ready;

  wf_table #(.K(K), .N(N), .DW(DW), .KW(KW), .CW(CW)) u_perf_tbl (
    .clk(clk), .rst_n(rst_n), .we(beat && !wr_sel),
    .wk(wr_kern), .wc(wr_cnt), .wd(wr_data), .q(perf_q)
  );

  wf_table #(.K(K), .N(N), .DW(DW), .KW(KW), .CW(CW)) u_cost_tbl (
    .clk(clk), .rst_n(rst_n), .we(beat && wr_sel),
    .wk(wr_kern), .wc(wr_cnt), .wd(wr_data), .q(cost_q)
  );

  wf_fit #(.K(K), .N(N), .DW(DW), .KW(KW), .CW(CW), .SW(SW), .PSW(PSW)) u_fit (
    .cnt(cnt_q), .perf_q(perf_q), .cost_q(cost_q), .sel(sel),
    .r_total(r_total), .cur_perf(cur_perf), .sum_cost(sum_cost),
    .perf_sum(perf_sum), .grow_ok(grow_ok)
  );

  wf_minsel #(.K(K), .DW(DW), .KW(KW)) u_minsel (
    .val(cur_perf), .idx(sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      spatial <= 1'b0;
      for (int i = 0; i < K; i++) cnt_q[i] <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            for (int i = 0; i < K; i++) cnt_q[i] <= CW'(1);
            spatial <= 1'b0;
            state_q <= ST_INIT;
          end
        end
        ST_INIT: begin
          if (sum_cost > SW'(r_total)) begin
            spatial <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (grow_ok) begin
            cnt_q[sel] <= cnt_q[sel] + 1'b1;
          end else begin
            spatial <= (perf_sum < thresh);
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < K; i++) begin : g_out
    assign cta_counts[i*CW +: CW] = cnt_q[i];
  end
endmodule

// File: rtl/wf_partition_checker.sv
module wf_partition_checker #(
  parameter int K  = 3,
  parameter int N  = 4,
  parameter int CW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            spatial,
  input logic            wr_ready,
  input logic [K*CW-1:0] cta_counts
);
  logic [15:0] tot;
  always_comb begin
    tot = '0;
    for (int i = 0; i < K; i++) tot = tot + 16'(cta_counts[i*CW +: CW]);
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cta_counts) && $stable(spatial)));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r1_no_beat_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wr_ready);

  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((tot == $past(tot)) || (tot == $past(tot) + 16'd1)));

  for (genvar k = 0; k < K; k++) begin : g_k
    a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cta_counts[k*CW +: CW] <= CW'(N));
    a_r3_one_each: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cta_counts[k*CW +: CW] == CW'(1)));
  end
endmodule

bind wf_partition_engine wf_partition_checker #(.K(K), .N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .spatial(spatial), .wr_ready(wr_ready), .cta_counts(cta_counts)
);

// File: tb/tb_wf_partition_engine.sv
`timescale 1ns/1ps
module tb_wf_partition_engine;
  localparam int K  = 3;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int KW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_sel = 1'b0;
  logic [KW-1:0] wr_kern = '0;
  logic [CW-1:0] wr_cnt = '0;
  logic [DW-1:0] wr_data = '0, r_total = '0;
  logic [DW+KW-1:0] thresh = '0;
  logic start = 1'b0;
  logic wr_ready, busy, done, spatial;
  logic [K*CW-1:0] cta_counts;

  int checks = 0, errors = 0;
  int pm [K][N];
  int cm [K][N];
  int exp_c [K];
  bit exp_sp;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wf_partition_engine #(.K(K), .N(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_kern(wr_kern), .wr_cnt(wr_cnt), .wr_data(wr_data),
    .r_total(r_total), .thresh(thresh), .start(start), .busy(busy),
    .done(done), .spatial(spatial), .cta_counts(cta_counts)
  );

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int cnt_of(int k);
    return int'(cta_counts[k*CW +: CW]);
  endfunction

  task automatic put(bit sel, int k, int t, int v);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_kern = KW'(k); wr_cnt = CW'(t); wr_data = DW'(v);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_tables();
    for (int k = 0; k < K; k++)
      for (int t = 0; t < N; t++) begin
        put(1'b0, k, t + 1, pm[k][t]);
        put(1'b1, k, t + 1, cm[k][t]);
      end
  endtask

  // reference greedy from the requirements
  task automatic model(int rt, int th);
    int sc, m, ps;
    sc = 0;
    for (int k = 0; k < K; k++) begin exp_c[k] = 1; sc += cm[k][0]; end
    if (sc > rt) begin exp_sp = 1; return; end
    forever begin
      m = 0;
      for (int k = 1; k < K; k++) if (pm[k][exp_c[k]-1] < pm[m][exp_c[m]-1]) m = k;
      if (exp_c[m] >= N) break;
      if (sc - cm[m][exp_c[m]-1] + cm[m][exp_c[m]] > rt) break;
      sc = sc - cm[m][exp_c[m]-1] + cm[m][exp_c[m]];
      exp_c[m]++;
    end
    ps = 0;
    for (int k = 0; k < K; k++) ps += pm[k][exp_c[k]-1];
    exp_sp = (ps < th);
  endtask

  task automatic run(string req, int rt, int th, bit init_fail);
    int cyc, sc;
    model(rt, th);
    r_total = DW'(rt); thresh = (DW+KW)'(th);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check("R9", "done seen", int'(done), 1);
    checks++;
    if (cyc > K*(N-1)+3) begin
      errors++;
      $display("FAIL R9 latency actual=%0d expected<=%0d", cyc, K*(N-1)+3);
    end
    for (int k = 0; k < K; k++) check(req, $sformatf("count k%0d", k), cnt_of(k), exp_c[k]);
    check(req, "spatial", int'(spatial), int'(exp_sp));
    if (!init_fail) begin
      sc = 0;
      for (int k = 0; k < K; k++) sc += cm[k][cnt_of(k)-1];
      checks++;
      if (sc > rt) begin
        errors++;
        $display("FAIL R6 cost sum actual=%0d expected<=%0d", sc, rt);
      end
    end
    @(negedge clk);
    check("R9", "done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    check("R10", "counts", int'(cta_counts), 0);
    check("R10", "busy", int'(busy), 0);
    check("R10", "done", int'(done), 0);
    check("R10", "spatial", int'(spatial), 0);
    check("R10", "wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_basic();
    int p0[N] = '{100, 180, 240, 280};
    int p1[N] = '{50, 90, 130, 160};
    int p2[N] = '{120, 200, 250, 270};
    for (int t = 0; t < N; t++) begin
      pm[0][t] = p0[t]; pm[1][t] = p1[t]; pm[2][t] = p2[t];
      for (int k = 0; k < K; k++) cm[k][t] = 10 * (t + 1);
    end
    load_tables();
    run("R4", 80, 0, 0);
    // hand trace: (2,4,2) with kernel 1 capped at N, budget used exactly
    check("R5", "k1 at cap", cnt_of(1), 4);
    check("R7", "k0", cnt_of(0), 2);
    check("R6", "k2", cnt_of(2), 2);
  endtask

  task automatic t_tie();
    for (int k = 0; k < K; k++)
      for (int t = 0; t < N; t++) begin pm[k][t] = 100 * (t + 1); cm[k][t] = 10 * (t + 1); end
    load_tables();
    run("R4", 50, 0, 0);
    // ties go to low index: (2,2,1), kernel 2 refused at 60 > 50
    check("R4", "tie k0", cnt_of(0), 2);
    check("R5", "refused k2", cnt_of(2), 1);
  endtask

  task automatic t_cap();
    run("R7", 16'hFFFF, 0, 0);
    for (int k = 0; k < K; k++) check("R7", "all at N", cnt_of(k), N);
  endtask

  task automatic t_init();
    for (int k = 0; k < K; k++)
      for (int t = 0; t < N; t++) cm[k][t] = 30 * (t + 1);
    load_tables();
    run("R3", 89, 0, 1);
    check("R3", "spatial on overflow", int'(spatial), 1);
    run("R3", 90, 0, 0);
    check("R3", "equal budget fits", int'(spatial), 0);
    check("R5", "no growth", cnt_of(0), 1);
  endtask

  task automatic t_thresh();
    // all at one CTA with costs 30 each and budget 90: perf sum is 300
    run("R8", 90, 300, 0);
    check("R8", "equal threshold", int'(spatial), 0);
    run("R8", 90, 301, 0);
    check("R8", "above threshold", int'(spatial), 1);
  endtask

  task automatic t_busy();
    int dones;
    for (int k = 0; k < K; k++)
      for (int t = 0; t < N; t++) begin pm[k][t] = 100 * (t + 1); cm[k][t] = 10 * (t + 1); end
    load_tables();
    model(50, 0);
    r_total = DW'(50); thresh = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    check("R1", "ready low while busy", int'(wr_ready), 0);
    // re-start and a beat that would make kernel 2 free, both while busy
    wr_valid = 1'b1; wr_sel = 1'b1; wr_kern = KW'(2); wr_cnt = CW'(2); wr_data = '0;
    @(negedge clk);
    start = 1'b0; wr_valid = 1'b0;
    dones = 0;
    for (int c = 0; c < 40; c++) begin
      if (done) dones++;
      @(negedge clk);
    end
    check("R2", "single done", dones, 1);
    check("R1", "beat ignored k2", cnt_of(2), exp_c[2]);
    check("R1", "beat ignored k1", cnt_of(1), exp_c[1]);
    check("R9", "hold after done", cnt_of(0), exp_c[0]);
    check("R9", "idle", int'(busy), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tie();
    t_cap();
    t_init();
    t_thresh();
    t_busy();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule